// File: doc/BRIEF.md
# Sequential Unsigned Shift-Add Multiplier

This block multiplies two unsigned operands over many clock cycles and returns the full double-width product. It trades speed for area: a single operand-wide adder and one double-width product register do all the work. One multiplier bit is retired per cycle.

When the unit is idle, a one-cycle `start` pulse latches both operands. The multiplier goes into the low half of the product register, and the high half is cleared. On each iteration the unit looks at the register's least significant bit. If that bit is set, the multiplicand is added into the high half. The whole register then shifts right by one, and the adder's carry-out enters at the top.

After one iteration per operand bit, `done` pulses and the product is presented. The product is held until the next accepted `start`. A `start` that arrives while the unit is busy has no effect.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `product` is all zeros until a start is accepted.
- R2: A `start` seen while `busy` is 0 is accepted at that clock edge: `busy` is 1 in the next cycle, and the operand values on that edge are the only ones used.
- R3: After an accepted start, `product` equals the unsigned 64-bit product of the captured multiplicand and multiplier when `done` is 1.
- R4: `busy` stays 1 for exactly 32 cycles after acceptance. `done` is 1 for exactly one cycle, the cycle right after `busy` falls, which is the 33rd cycle after the accepting edge.
- R5: A `start` asserted while `busy` is 1 is ignored. The running result, and the timing of `busy` and `done`, are the same as without it.
- R6: Once `done` has pulsed, `product` keeps its value, whatever happens on the operand inputs, until the next accepted start.
- R7: Carries out of the high-half addition are kept by shifting them into the product's most significant bit. With both operands at 0xFFFFFFFF, the product is 0xFFFFFFFE00000001.
- R8: A zero multiplicand or a zero multiplier gives a product of zero. Multiplying by one returns the other operand zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request a new multiplication; honoured only when idle |
| multiplicand | input | 32 | Unsigned multiplicand, sampled when start is accepted |
| multiplier | input | 32 | Unsigned multiplier, sampled when start is accepted |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 64 | Unsigned 64-bit product, held until the next accepted start |

## Verification
Directed operands cover several cases, and each exposes a different fault:
- Zero and one operands show whether the conditional add is gated by the correct bit.
- All-ones operands show whether the carry is lost instead of being shifted into the top.
- A single top bit set in each operand shows an off-by-one in the iteration count.

Random operands from a fixed seed exercise mixed bit patterns against a behavioural multiply. Some runs scramble the operand inputs right after the start pulse, or raise start again in mid-operation, to tell correct operand capture apart from a unit that keeps listening to its inputs.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

  typedef enum logic {
    MUL_IDLE = 1'b0,
    MUL_RUN  = 1'b1
  } mul_state_e;

endpackage

// File: rtl/sam_rst_sync.sv
module sam_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sam_adder.sv
module sam_adder #(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);

  generate
    if (RIPPLE) begin : g_ripple
      logic [W:0] c;
      assign c[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ b[i] ^ c[i];
        assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
      end
      assign cout = c[W];
    end else begin : g_behav
      logic [W:0] full;
      assign full = {1'b0, a} + {1'b0, b};
      assign sum  = full[W-1:0];
      assign cout = full[W];
    end
  endgenerate

endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int OP_W  = 32,
  parameter int CNT_W = $clog2(OP_W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic step_en,
  output logic busy,
  output logic done
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OP_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  mul_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             accept;

  assign accept = start && (state_q == MUL_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (accept) begin
      state_d = MUL_RUN;
      cnt_d   = CNT_FULL;
    end else if (state_q == MUL_RUN) begin
      cnt_d = cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        state_d = MUL_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MUL_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign load_en = accept;
  assign step_en = (state_q == MUL_RUN);
  assign busy    = (state_q == MUL_RUN);
  assign done    = done_q;

  // R2
  accept_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && cnt_q == CNT_FULL));

  // R5
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != CNT_ONE) |=> (busy && cnt_q == $past(cnt_q) - CNT_ONE));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R4
  busy_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));

endmodule

// File: rtl/sam_dpath.sv
module sam_dpath #(
  parameter int OP_W   = 32,
  parameter bit RIPPLE = 1'b0,
  parameter int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [OP_W-1:0]   mcand_in,
  input  logic [OP_W-1:0]   mplier_in,
  output logic [PROD_W-1:0] prod
);

  logic [OP_W-1:0]   mcand_q, mcand_d;
  logic [PROD_W-1:0] prod_q, prod_d;
  logic [OP_W-1:0]   hi_cur, add_sum, hi_sel;
  logic              add_cout, carry_sel, take_add;

  assign hi_cur   = prod_q[PROD_W-1:OP_W];
  assign take_add = prod_q[0];

  sam_adder #(.W(OP_W), .RIPPLE(RIPPLE)) u_add (
    .a    (hi_cur),
    .b    (mcand_q),
    .sum  (add_sum),
    .cout (add_cout)
  );

  always_comb begin
    hi_sel    = take_add ? add_sum  : hi_cur;
    carry_sel = take_add ? add_cout : 1'b0;
  end

  always_comb begin
    mcand_d = mcand_q;
    prod_d  = prod_q;
    if (load_en) begin
      mcand_d = mcand_in;
      prod_d  = {{OP_W{1'b0}}, mplier_in};
    end else if (step_en) begin
      prod_d = {carry_sel, hi_sel, prod_q[OP_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else begin
      mcand_q <= mcand_d;
      prod_q  <= prod_d;
    end
  end

  assign prod = prod_q;

  // R2
  load_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (prod_q[PROD_W-1:OP_W] == '0 && prod_q[OP_W-1:0] == $past(mplier_in)));

  // R7
  no_add_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !prod_q[0]) |=> (prod_q[PROD_W-1] == 1'b0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load_en) |=> $stable(prod_q));

  // R2
  mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(mcand_q));

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int OP_W   = 32,
  parameter bit RIPPLE = 1'b0,
  parameter int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   multiplicand,
  input  logic [OP_W-1:0]   multiplier,
  output logic              busy,
  output logic              done,
  output logic [PROD_W-1:0] product
);

  logic rst_int_n;
  logic load_en, step_en;

  sam_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  sam_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .load_en (load_en),
    .step_en (step_en),
    .busy    (busy),
    .done    (done)
  );

  sam_dpath #(.OP_W(OP_W), .RIPPLE(RIPPLE)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (load_en),
    .step_en   (step_en),
    .mcand_in  (multiplicand),
    .mplier_in (multiplier),
    .prod      (product)
  );

  // R4
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(busy && done));

endmodule

// File: tb/shift_add_mul_tb_top.sv
module shift_add_mul_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] multiplicand, multiplier;
  logic        busy, done;
  logic [63:0] product;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  shift_add_mul dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    return 64'(a) * 64'(b);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // One multiplication; optionally scramble operands and/or inject a busy-time start.
  task automatic run_mul(input logic [31:0] a, input logic [31:0] b,
                         input bit scramble, input bit inject);
    logic [63:0] exp, got;
    int busy_cnt, done_cnt, done_at;
    exp = ref_mul(a, b);
    busy_cnt = 0; done_cnt = 0; done_at = 0; got = '0;
    @(negedge clk);
    start = 1'b1; multiplicand = a; multiplier = b;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (j == 1) begin
        start = 1'b0;
        if (scramble) begin multiplicand = ~a ^ 32'h5A5A_0F0F; multiplier = b + 32'd77; end
      end
      if (inject && j == 6) begin
        start = 1'b1; multiplicand = 32'hDEAD_BEEF; multiplier = 32'h1234_5678;
      end
      if (inject && j == 7) start = 1'b0;
      if (busy) busy_cnt++;
      if (done) begin done_cnt++; if (done_at == 0) begin done_at = j; got = product; end end
    end
    // R3 product correct at done
    check(got == exp, "R3", got, exp);
    // R4 timing: busy 32 cycles, done one cycle at the 33rd negedge
    check(busy_cnt == 32 && done_cnt == 1 && done_at == 33, "R4",
          64'(done_at), 64'd33);
    // R6 product held after done while operands wander
    multiplicand = $urandom; multiplier = $urandom;
    repeat (3) @(negedge clk);
    check(product == exp && !busy, "R6", product, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0x%016h expected=0x%016h", 64'd0, 64'd1);
    report();
  end

  initial begin
    void'($urandom(32'd20240613));
    rst_n = 1'b0; start = 1'b0; multiplicand = '0; multiplier = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && product == '0, "R1", product, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && product == '0, "R1", product, 64'd0);

    // R2 acceptance: busy the cycle after the start edge
    start = 1'b1; multiplicand = 32'd11; multiplier = 32'd13;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", 64'(busy), 64'd1);
    repeat (40) @(negedge clk);
    // R3 small worked case 11*13 = 143
    check(product == 64'd143, "R3", product, 64'd143);

    // R7 carry chain at full scale
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check(product == 64'hFFFF_FFFE_0000_0001, "R7", product, 64'hFFFF_FFFE_0000_0001);
    run_mul(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
    check(product == 64'h4000_0000_0000_0000, "R7", product, 64'h4000_0000_0000_0000);

    // R8 zero and one operands
    run_mul(32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check(product == 64'd0, "R8", product, 64'd0);
    run_mul(32'hFFFF_FFFF, 32'h0, 1'b0, 1'b0);
    check(product == 64'd0, "R8", product, 64'd0);
    run_mul(32'h1, 32'hCAFE_F00D, 1'b0, 1'b0);
    check(product == 64'h0000_0000_CAFE_F00D, "R8", product, 64'hCAFE_F00D);
    run_mul(32'h8765_4321, 32'h1, 1'b0, 1'b0);
    check(product == 64'h0000_0000_8765_4321, "R8", product, 64'h8765_4321);

    // R2 operand capture: inputs scrambled after the start edge
    run_mul(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1'b0);
    // R5 start during busy is ignored
    run_mul(32'hFFFF_0001, 32'h0003_FFFF, 1'b0, 1'b1);
    run_mul(32'h7FFF_FFFF, 32'h8000_0001, 1'b1, 1'b1);

    for (int k = 0; k < 40; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (k % 8 == 3) ra = ra | 32'hFFFF_0000;
      if (k % 8 == 5) rb = rb & 32'h0000_00FF;
      run_mul(ra, rb, k[0], k[1] & k[2]);
    end

    report();
  end

endmodule